// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks one vector operation in which the source operand and the destination operand each carry their own predicate mask. After a start pulse it keeps a source step and a destination step. Each step moves past the element positions whose mask bit is clear, and the two step counters do this independently of each other. When both steps rest on set mask bits, the block emits the pair of element indices with a valid strobe. Both steps then move on by one.

The loop ends as soon as either step reaches the vector length. The block then pulses done and clears both steps to zero. Each mask can be used as given or bitwise inverted, chosen by a select input. The starting steps may be nonzero, so a loop that was interrupted can resume from saved step values. The live step values are visible on outputs so that they can be saved.

A consumer uses each emitted pair to read source element `srcIdx` and write destination element `dstIdx`. A destination element whose mask bit is clear is never named, so its register stays unwritten.

Top module: `twinpred_seq`

## Requirements
- R1: A start pulse taken while idle captures the vector length, both starting steps and both masks. A mask is inverted bit by bit when its invert select (`srcInvert`, `dstInvert`) is 1, and used unchanged when it is 0.
- R2: A source position whose effective mask bit is 0 is never emitted. The source step moves past it by one position per cycle, independently of the destination step.
- R3: A destination position whose effective mask bit is 0 is never emitted, so its register is never written. The destination step moves past it independently of the source step.
- R4: While both steps are below the vector length and both effective mask bits are 1, `pairValid` is high with `srcIdx`/`dstIdx` equal to the current steps. Both steps then advance by one. At most one pair is emitted per cycle.
- R5: `done` pulses for one cycle when either step is at or beyond the vector length, and `pairValid` is never high in that cycle. Set source bits at or beyond the vector length are never used.
- R6: Nonzero starting steps resume the loop from those positions, and skipping applies from there on.
- R7: A vector length of 0, or a starting step at or beyond the vector length, gives `done` in the first cycle after start with no pair emitted.
- R8: `srcStepOut`/`dstStepOut` show the live steps and are both 0 in the cycle after `done`.
- R9: A start pulse while busy is ignored, and the running loop produces the same pairs it would have produced without it.
- R10: A vector length above `MAXVL` is treated as `MAXVL`.
- R11: `busy` is high from the cycle after the accepted start through the `done` cycle, and low after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| vecLen | input | STEP_W | Vector length |
| srcStepInit | input | STEP_W | Starting source step |
| dstStepInit | input | STEP_W | Starting destination step |
| srcMask | input | MAXVL | Source predicate mask, bit i for element i |
| dstMask | input | MAXVL | Destination predicate mask, bit i for element i |
| srcInvert | input | 1 | 1 selects the inverted source mask |
| dstInvert | input | 1 | 1 selects the inverted destination mask |
| busy | output | 1 | Loop running |
| pairValid | output | 1 | An index pair is valid this cycle |
| srcIdx | output | STEP_W | Source element index of the pair |
| dstIdx | output | STEP_W | Destination element index of the pair |
| done | output | 1 | One-cycle end-of-loop pulse |
| srcStepOut | output | STEP_W | Live source step |
| dstStepOut | output | STEP_W | Live destination step |

## Verification
The hardest case to reach from the ports is the one where the two steps drift apart. One step sits on a set bit and waits while the other walks over a run of clear bits, and the loop must then end on whichever step runs out first. The stimulus sets this up with complementary masks and offset resume steps, including one case where a set source bit lies past the point where the destination runs out. A scoreboard holds the pairs expected from an independent model of the masks. A sign-extend-byte datapath in the bench turns every pair into a register write, so skipped destination registers can be seen to stay untouched. A start pulse injected mid-loop shows that a running operation cannot be disturbed.

// File: rtl/twp_pkg.sv
package twp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands
    logic advSrc;  // source step +1
    logic advDst;  // destination step +1
    logic clear;   // loop finished: zero the steps
  } ctrlStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic srcOut;  // source step at/after vector length
    logic dstOut;  // destination step at/after vector length
    logic srcBit;  // effective source mask bit at the step
    logic dstBit;  // effective destination mask bit at the step
  } dpStatus_t;

endpackage

// File: rtl/twp_datapath.sv
module twp_datapath
  import twp_pkg::*;
#(
  parameter int MAXVL  = 16,
  parameter int STEP_W = $clog2(MAXVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strb,
  input  logic [STEP_W-1:0]  vecLen,
  input  logic [STEP_W-1:0]  srcStepInit,
  input  logic [STEP_W-1:0]  dstStepInit,
  input  logic [MAXVL-1:0]   srcMask,
  input  logic [MAXVL-1:0]   dstMask,
  input  logic               srcInvert,
  input  logic               dstInvert,
  output dpStatus_t          stat,
  output logic [STEP_W-1:0]  srcStep,
  output logic [STEP_W-1:0]  dstStep
);

  localparam int IDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1;
  localparam logic [STEP_W-1:0] MAXVL_C = STEP_W'(MAXVL);

  logic [STEP_W-1:0] vlReg;
  logic [MAXVL-1:0]  srcMaskReg;
  logic [MAXVL-1:0]  dstMaskReg;
  logic [STEP_W-1:0] vlClamped;

  assign vlClamped = (vecLen > MAXVL_C) ? MAXVL_C : vecLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vlReg      <= '0;
      srcMaskReg <= '0;
      dstMaskReg <= '0;
    end else if (strb.load) begin
      vlReg      <= vlClamped;
      srcMaskReg <= srcInvert ? ~srcMask : srcMask;
      dstMaskReg <= dstInvert ? ~dstMask : dstMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcStep <= '0;
      dstStep <= '0;
    end else if (strb.load) begin
      srcStep <= srcStepInit;
      dstStep <= dstStepInit;
    end else if (strb.clear) begin
      srcStep <= '0;
      dstStep <= '0;
    end else begin
      if (strb.advSrc) srcStep <= srcStep + 1'b1;
      if (strb.advDst) dstStep <= dstStep + 1'b1;
    end
  end

  always_comb begin
    stat.srcOut = (srcStep >= vlReg);
    stat.dstOut = (dstStep >= vlReg);
    stat.srcBit = !stat.srcOut && srcMaskReg[srcStep[IDX_W-1:0]];
    stat.dstBit = !stat.dstOut && dstMaskReg[dstStep[IDX_W-1:0]];
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (srcStep == '0 && dstStep == '0));

  // R5
  no_adv_past_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advSrc || strb.advDst) |-> (!stat.srcOut && !stat.dstOut));

  // R10
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlReg <= MAXVL_C);

endmodule

// File: rtl/twp_control.sv
module twp_control
  import twp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         pairValid,
  output logic         done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  logic running;
  logic anyOut;

  assign running = (state == ST_RUN);
  assign anyOut  = stat.srcOut || stat.dstOut;

  always_comb begin
    pairValid   = running && !anyOut && stat.srcBit && stat.dstBit;
    done        = running && anyOut;
    strb.load   = !running && start;
    strb.clear  = done;
    strb.advSrc = running && !anyOut && (pairValid || !stat.srcBit);
    strb.advDst = running && !anyOut && (pairValid || !stat.dstBit);
  end

  assign busy = running;

  always_ff @(posedge clk) begin
    if (!rst_n)          state <= ST_IDLE;
    else if (strb.load)  state <= ST_RUN;
    else if (done)       state <= ST_IDLE;
  end

  // R5
  pair_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pairValid && done));

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R4
  pair_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |-> (strb.advSrc && strb.advDst));

endmodule

// File: rtl/twinpred_seq.sv
module twinpred_seq
  import twp_pkg::*;
#(
  parameter int MAXVL  = 16,
  parameter int STEP_W = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [STEP_W-1:0] srcStepInit,
  input  logic [STEP_W-1:0] dstStepInit,
  input  logic [MAXVL-1:0]  srcMask,
  input  logic [MAXVL-1:0]  dstMask,
  input  logic              srcInvert,
  input  logic              dstInvert,
  output logic              busy,
  output logic              pairValid,
  output logic [STEP_W-1:0] srcIdx,
  output logic [STEP_W-1:0] dstIdx,
  output logic              done,
  output logic [STEP_W-1:0] srcStepOut,
  output logic [STEP_W-1:0] dstStepOut
);

  ctrlStrobes_t strb;
  dpStatus_t    stat;
  logic [STEP_W-1:0] srcStep;
  logic [STEP_W-1:0] dstStep;

  twp_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stat(stat), .strb(strb),
    .busy(busy), .pairValid(pairValid), .done(done)
  );

  twp_datapath #(.MAXVL(MAXVL), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .vecLen(vecLen),
    .srcStepInit(srcStepInit), .dstStepInit(dstStepInit),
    .srcMask(srcMask), .dstMask(dstMask),
    .srcInvert(srcInvert), .dstInvert(dstInvert),
    .stat(stat), .srcStep(srcStep), .dstStep(dstStep)
  );

  assign srcIdx     = srcStep;
  assign dstIdx     = dstStep;
  assign srcStepOut = srcStep;
  assign dstStepOut = dstStep;

endmodule

// File: tb/sim_twinpred_seq.sv
module sim_twinpred_seq;

  localparam int MAXVL  = 16;
  localparam int STEP_W = $clog2(MAXVL + 1);
  localparam int SRC_BASE = 20;
  localparam int DST_BASE = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [STEP_W-1:0] vecLen = '0, srcStepInit = '0, dstStepInit = '0;
  logic [MAXVL-1:0]  srcMask = '0, dstMask = '0;
  logic srcInvert = 0, dstInvert = 0;
  logic busy, pairValid, done;
  logic [STEP_W-1:0] srcIdx, dstIdx, srcStepOut, dstStepOut;

  always #5 clk = ~clk;

  twinpred_seq #(.MAXVL(MAXVL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .srcStepInit(srcStepInit), .dstStepInit(dstStepInit),
    .srcMask(srcMask), .dstMask(dstMask),
    .srcInvert(srcInvert), .dstInvert(dstInvert),
    .busy(busy), .pairValid(pairValid), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .done(done), .srcStepOut(srcStepOut), .dstStepOut(dstStepOut)
  );

  int checks = 0;
  int errors = 0;
  int expSrcQ[$];
  int expDstQ[$];
  string curReq = "R4";
  logic [63:0] rf [0:63];
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sext8(input logic [63:0] v);
    return {{56{v[7]}}, v[7:0]};
  endfunction

  // Monitor: pops the scoreboard and performs the element write
  always @(negedge clk) begin
    if (rst_n && pairValid) begin
      if (expSrcQ.size() == 0) begin
        chk(0, curReq, "unexpected pair src", 64'(srcIdx), 64'hffff);
      end else begin
        int es, ed;
        es = expSrcQ.pop_front();
        ed = expDstQ.pop_front();
        chk(int'(srcIdx) == es, curReq, "pair srcIdx", 64'(srcIdx), 64'(es));
        chk(int'(dstIdx) == ed, curReq, "pair dstIdx", 64'(dstIdx), 64'(ed));
        rf[DST_BASE + int'(dstIdx)] = sext8(rf[SRC_BASE + int'(srcIdx)]);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver: builds the expected pairs from the mask rules, then runs the op
  task automatic runOp(input string req, input int vl, input int si, input int di,
                       input logic [MAXVL-1:0] sm, input logic [MAXVL-1:0] dm,
                       input bit sinv, input bit dinv, input bit poke,
                       input bit expectFast);
    logic [MAXVL-1:0] se, de;
    int s, d, vlc, n;
    se = sinv ? ~sm : sm;
    de = dinv ? ~dm : dm;
    vlc = (vl > MAXVL) ? MAXVL : vl;
    s = si; d = di;
    forever begin
      while (s < vlc && !se[s]) s++;
      while (d < vlc && !de[d]) d++;
      if (s >= vlc || d >= vlc) break;
      expSrcQ.push_back(s);
      expDstQ.push_back(d);
      s++; d++;
    end
    curReq = req;
    @(negedge clk);
    vecLen = STEP_W'(vl); srcStepInit = STEP_W'(si); dstStepInit = STEP_W'(di);
    srcMask = sm; dstMask = dm; srcInvert = sinv; dstInvert = dinv;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'd1);
    if (expectFast)
      chk(done == 1'b1, "R7", "done on first cycle", 64'(done), 64'd1);
    if (poke && !done) begin
      srcMask = '1; dstMask = '1; vecLen = STEP_W'(MAXVL);
      srcStepInit = '0; dstStepInit = '0; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R5", "done reached", 64'(done), 64'd1);
    @(negedge clk);
    chk(expSrcQ.size() == 0, req, "pairs missing", 64'(expSrcQ.size()), 64'd0);
    chk(busy == 1'b0 && done == 1'b0, "R11", "idle after done",
        64'({busy, done}), 64'd0);
    chk(srcStepOut == '0 && dstStepOut == '0, "R8", "steps cleared",
        64'({srcStepOut, dstStepOut}), 64'd0);
    expSrcQ.delete();
    expDstQ.delete();
  endtask

  task automatic clearRf();
    for (int i = 0; i < 64; i++) rf[i] = 64'h0;
  endtask

  initial begin
    clearRf();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(busy == 0 && pairValid == 0 && done == 0, "R11", "reset outputs",
        64'({busy, pairValid, done}), 64'd0);
    chk(srcStepOut == 0 && dstStepOut == 0, "R8", "reset steps",
        64'({srcStepOut, dstStepOut}), 64'd0);

    // R2 R3: vl 3, src 101, dst = ~101 -> 010 via invert (R1)
    clearRf();
    rf[SRC_BASE+0] = 64'h90; rf[SRC_BASE+1] = 64'h91; rf[SRC_BASE+2] = 64'h92;
    runOp("R3", 3, 0, 0, 16'b101, 16'b101, 0, 1, 0, 0);
    chk(rf[DST_BASE+1] == 64'hFFFF_FFFF_FFFF_FF90, "R3", "dst1 written",
        rf[DST_BASE+1], 64'hFFFF_FFFF_FFFF_FF90);
    chk(rf[DST_BASE+0] == 0 && rf[DST_BASE+2] == 0, "R3", "masked dst untouched",
        rf[DST_BASE+0] | rf[DST_BASE+2], 64'd0);

    // R6: resume at src 1 / dst 2, src 0101, dst 1010
    clearRf();
    rf[SRC_BASE+2] = 64'h92;
    runOp("R6", 4, 1, 2, 16'b0101, 16'b1010, 0, 0, 0, 0);
    chk(rf[DST_BASE+3] == 64'hFFFF_FFFF_FFFF_FF92, "R6", "dst3 written",
        rf[DST_BASE+3], 64'hFFFF_FFFF_FFFF_FF92);
    chk(rf[DST_BASE+2] == 0, "R6", "dst2 untouched", rf[DST_BASE+2], 64'd0);

    // R4: full masks at MAXVL, one pair per cycle
    runOp("R4", MAXVL, 0, 0, '1, '1, 0, 0, 0, 0);
    // R2: sparse source, dense dest, steps drift apart
    runOp("R2", 12, 0, 0, 16'b1000_1001_0010, '1, 0, 0, 0, 0);
    // R1: source inverted
    runOp("R1", 8, 0, 0, 16'b1111_0110, 16'b0011_1101, 1, 0, 0, 0);
    // R5: destination runs out while set source bits remain
    runOp("R5", 10, 0, 6, 16'h3FF, 16'b00_0100_0000, 0, 0, 0, 0);
    // R7: zero length, and starting step at/after length
    runOp("R7", 0, 0, 0, '1, '1, 0, 0, 0, 1);
    runOp("R7", 5, 5, 0, '1, '1, 0, 0, 0, 1);
    // R10: length above MAXVL is clamped
    runOp("R10", MAXVL + 4, 0, 0, '1, '1, 0, 0, 0, 0);
    // R9: start pulse during a run is ignored
    runOp("R9", 9, 0, 1, 16'b1_0101_0101, 16'b0_1100_1100, 0, 0, 1, 0);
    // zero masks: no pairs
    runOp("R2", 6, 0, 0, '0, '1, 0, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule